// File: doc/BRIEF.md
# CPU Extraction Word Stream Decoder

This block sits between a frame extraction queue and the CPU-side consumer. The queue hands over raw 32-bit words with a valid/ready handshake. A small set of reserved word values act as in-band control codes. They mark the end of a frame together with how many bytes of the final word are valid. They also mark a pruned frame, an aborted frame and a "queue not ready" poll result. One code escapes the word that follows it. The decoder strips these codes and emits a clean word stream. Each output word carries a valid-byte count, a last flag and a header flag, and a separate one-cycle abort flag reports frames that fail.

Every frame begins with a fixed-length prefix header of `HDR_WORDS` words. The decoder tags these words as header and checks that no frame-ending or not-ready code appears once collection has started. After the header the decoder is in payload mode. An end-of-frame or pruned code arms the final-word state. The next word, unescaped if it is preceded by an escape, is then emitted as the last word. Output is registered: a word accepted at a clock edge produces its output beat in the cycle that follows that edge.

Top module: `xtr_word_decoder`

## Requirements
- R1: During reset and in the first cycle after it, every output flag is low. From the first clock edge after reset release, `raw_ready_o` is high.
- R2: In payload mode, a word that is not a control code is emitted one cycle after it is accepted, with byte count 4, last low and header low. Cycles with no accepted word produce no beat.
- R3: The first `HDR_WORDS` data words of each frame are emitted with the header flag high and byte count 4. Later words have the header flag low.
- R4: The not-ready code (default 32'h8000_0007) is dropped without any output when it arrives in payload mode or before the first header word of a frame.
- R5: The abort code (default 32'h8000_0006) in payload mode produces a one-cycle abort pulse with no valid beat. The next data word is then the first header word of a new frame.
- R6: The end-of-frame codes EOF_BASE+k, with EOF_BASE defaulting to 32'h8000_0000 and k from 0 to 3, set the byte count of the next word to 4, 1, 2 and 3 for k = 0, 1, 2 and 3. That next word is emitted with last high.
- R7: The pruned code (default 32'h8000_0004) makes the next word a final word with byte count 4 and last high.
- R8: The escape code (default 32'h8000_0005) produces no output. The word after it is emitted as data with 4 valid bytes, even when that word equals a control code.
- R9: If an escape code follows an end-of-frame or pruned code, the word after the escape is the final word, with the armed byte count and last high.
- R10: Once the final word is armed, any unescaped word other than the escape code, control codes included, is emitted as the final word.
- R11: While the header is being collected, an abort, end-of-frame or pruned code, or a not-ready code after at least one header word, produces an abort pulse. Header collection then restarts from its first word.
- R12: After a last beat, the next data word starts a new frame and is emitted with the header flag high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_data_i | input | 32 | Raw word from the extraction queue |
| raw_valid_i | input | 1 | Raw word present |
| raw_ready_o | output | 1 | Decoder accepts a word |
| out_data_o | output | 32 | Decoded data word |
| out_bytes_o | output | 3 | Valid bytes in the word, 1 to 4 |
| out_valid_o | output | 1 | Output beat present |
| out_last_o | output | 1 | Beat is the final word of the frame |
| out_hdr_o | output | 1 | Beat belongs to the prefix header |
| out_abort_o | output | 1 | One-cycle pulse: current frame aborted |

## Verification
The bench targets the escape corner cases. These are an escape followed by a control code, two escapes in a row, and an escape placed between an end-of-frame code and the final word. A decoder that mishandled them would end frames early, drop escapes that should pass, or emit the escape itself. It sends control codes as the final word, where a decoder that re-interprets them would abort or hang in the final state instead of closing the frame. It puts not-ready codes at the start of the header and in the middle of it: one place is harmless and the other must abort, so a decoder treating both the same is caught. A long stream of mixed codes with gaps in the valid signal is compared on every cycle with a behavioural model, which exposes wrong byte counts for each end-of-frame code and header counters that do not restart.

// File: rtl/xtr_word_pkg.sv
package xtr_word_pkg;

  typedef enum logic [2:0] {
    K_DATA,
    K_EOF,
    K_PRUNED,
    K_ABORT,
    K_ESCAPE,
    K_IDLE
  } word_kind_e;

  typedef enum logic [1:0] {
    ST_HEADER,
    ST_PAYLOAD,
    ST_FINAL
  } dec_state_e;

  typedef struct packed {
    logic valid;
    logic abort;
    logic last;
    logic hdr;
  } beat_flags_t;

endpackage

// File: rtl/xtr_code_classify.sv
module xtr_code_classify
  import xtr_word_pkg::*;
#(
  parameter int                  DATA_W      = 32,
  parameter int                  BYTES_W     = 3,
  parameter logic [DATA_W-1:0]   EOF_BASE    = 32'h8000_0000,
  parameter logic [DATA_W-1:0]   PRUNED_CODE = 32'h8000_0004,
  parameter logic [DATA_W-1:0]   ESCAPE_CODE = 32'h8000_0005,
  parameter logic [DATA_W-1:0]   ABORT_CODE  = 32'h8000_0006,
  parameter logic [DATA_W-1:0]   IDLE_CODE   = 32'h8000_0007
) (
  input  logic [DATA_W-1:0]  word_i,
  output word_kind_e         kind_o,
  output logic [BYTES_W-1:0] bytes_o
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic [WORD_BYTES-1:0] eof_hit;

  // one end-of-frame code per residual byte count; index 0 means a full word
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_eof
    assign eof_hit[g] = (word_i == EOF_BASE + DATA_W'(g));
  end

  always_comb begin
    kind_o  = K_DATA;
    bytes_o = BYTES_W'(WORD_BYTES);
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (eof_hit[i]) begin
        kind_o  = K_EOF;
        bytes_o = (i == 0) ? BYTES_W'(WORD_BYTES) : BYTES_W'(i);
      end
    end
    if (word_i == PRUNED_CODE) kind_o = K_PRUNED;
    if (word_i == ESCAPE_CODE) kind_o = K_ESCAPE;
    if (word_i == ABORT_CODE)  kind_o = K_ABORT;
    if (word_i == IDLE_CODE)   kind_o = K_IDLE;
  end

endmodule

// File: rtl/xtr_frame_fsm.sv
module xtr_frame_fsm
  import xtr_word_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTES_W   = 3,
  parameter int HDR_WORDS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic [DATA_W-1:0]  word_i,
  input  word_kind_e         kind_i,
  input  logic [BYTES_W-1:0] bytes_i,
  output beat_flags_t        beat_o,
  output logic [BYTES_W-1:0] beat_bytes_o,
  output logic [DATA_W-1:0]  beat_data_o,
  output dec_state_e         state_o,
  output logic               esc_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int CNT_W      = $clog2(HDR_WORDS + 1);

  dec_state_e         state_q, state_d;
  logic               esc_q, esc_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTES_W-1:0] fin_q, fin_d;
  logic               take_lit;
  logic               kill;

  always_comb begin
    state_d      = state_q;
    esc_d        = esc_q;
    cnt_d        = cnt_q;
    fin_d        = fin_q;
    take_lit     = 1'b0;
    kill         = 1'b0;
    beat_o       = '0;
    beat_bytes_o = '0;
    beat_data_o  = word_i;

    if (acc_i) begin
      if (esc_q) begin
        esc_d    = 1'b0;
        take_lit = 1'b1;
      end else begin
        case (state_q)
          ST_HEADER: begin
            case (kind_i)
              K_DATA:   take_lit = 1'b1;
              K_ESCAPE: esc_d    = 1'b1;
              K_IDLE:   kill     = (cnt_q != '0); // harmless before the frame starts
              default:  kill     = 1'b1;
            endcase
          end
          ST_PAYLOAD: begin
            case (kind_i)
              K_DATA:   take_lit = 1'b1;
              K_ESCAPE: esc_d    = 1'b1;
              K_ABORT:  kill     = 1'b1;
              K_EOF, K_PRUNED: begin
                fin_d   = bytes_i;
                state_d = ST_FINAL;
              end
              default: ;
            endcase
          end
          default: begin
            if (kind_i == K_ESCAPE) esc_d = 1'b1;
            else                    take_lit = 1'b1;
          end
        endcase
      end

      if (take_lit) begin
        beat_o.valid = 1'b1;
        case (state_q)
          ST_HEADER: begin
            beat_o.hdr   = 1'b1;
            beat_bytes_o = BYTES_W'(WORD_BYTES);
            if (cnt_q == CNT_W'(HDR_WORDS - 1)) begin
              cnt_d   = '0;
              state_d = ST_PAYLOAD;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_PAYLOAD: beat_bytes_o = BYTES_W'(WORD_BYTES);
          default: begin
            beat_o.last  = 1'b1;
            beat_bytes_o = fin_q;
            state_d      = ST_HEADER;
            cnt_d        = '0;
          end
        endcase
      end

      if (kill) begin
        beat_o.abort = 1'b1;
        state_d      = ST_HEADER;
        cnt_d        = '0;
        esc_d        = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HEADER;
      esc_q   <= 1'b0;
      cnt_q   <= '0;
      fin_q   <= '0;
    end else begin
      state_q <= state_d;
      esc_q   <= esc_d;
      cnt_q   <= cnt_d;
      fin_q   <= fin_d;
    end
  end

  assign state_o = state_q;
  assign esc_o   = esc_q;

  assert_hdr_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(HDR_WORDS))
    else $error("header counter out of range");

  assert_cnt_idle_outside_hdr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HEADER) |-> (cnt_q == '0))
    else $error("header counter live outside header");

  assert_fin_bytes_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FINAL) |-> (fin_q != '0 && fin_q <= BYTES_W'(WORD_BYTES)))
    else $error("armed byte count out of range");

endmodule

// File: rtl/xtr_beat_reg.sv
module xtr_beat_reg
  import xtr_word_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTES_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  beat_flags_t        beat_i,
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic [DATA_W-1:0]  data_i,
  output beat_flags_t        beat_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic [DATA_W-1:0]  data_o
);
  localparam int WORD_BYTES = DATA_W / 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o  <= '0;
      bytes_o <= '0;
      data_o  <= '0;
    end else begin
      beat_o  <= beat_i;
      bytes_o <= bytes_i;
      data_o  <= data_i;
    end
  end

  assert_abort_no_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o.abort |-> !beat_o.valid)
    else $error("abort pulse carries a beat");

  assert_bytes_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o.valid |-> (bytes_o != '0 && bytes_o <= BYTES_W'(WORD_BYTES)))
    else $error("byte count out of range");

  assert_full_unless_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o.valid && !beat_o.last) |-> (bytes_o == BYTES_W'(WORD_BYTES)))
    else $error("partial word not marked last");

  assert_hdr_not_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o.last || beat_o.hdr) |-> (beat_o.valid && !(beat_o.last && beat_o.hdr)))
    else $error("flag combination invalid");

endmodule

// File: rtl/xtr_word_decoder.sv
module xtr_word_decoder
  import xtr_word_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                HDR_WORDS   = 4,
  parameter logic [DATA_W-1:0] EOF_BASE    = 32'h8000_0000,
  parameter logic [DATA_W-1:0] PRUNED_CODE = 32'h8000_0004,
  parameter logic [DATA_W-1:0] ESCAPE_CODE = 32'h8000_0005,
  parameter logic [DATA_W-1:0] ABORT_CODE  = 32'h8000_0006,
  parameter logic [DATA_W-1:0] IDLE_CODE   = 32'h8000_0007
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       raw_data_i,
  input  logic              raw_valid_i,
  output logic              raw_ready_o,
  output logic [31:0]       out_data_o,
  output logic [2:0]        out_bytes_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              out_hdr_o,
  output logic              out_abort_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTES_W    = $clog2(WORD_BYTES + 1);

  logic               rdy_q;
  logic               acc;
  word_kind_e         kind;
  logic [BYTES_W-1:0] kind_bytes;
  beat_flags_t        beat_nxt, beat_q;
  logic [BYTES_W-1:0] bytes_nxt;
  logic [DATA_W-1:0]  data_nxt;
  dec_state_e         state;
  logic               esc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end

  assign raw_ready_o = rdy_q;
  assign acc         = raw_valid_i & rdy_q;

  xtr_code_classify #(
    .DATA_W(DATA_W), .BYTES_W(BYTES_W), .EOF_BASE(EOF_BASE),
    .PRUNED_CODE(PRUNED_CODE), .ESCAPE_CODE(ESCAPE_CODE),
    .ABORT_CODE(ABORT_CODE), .IDLE_CODE(IDLE_CODE)
  ) u_classify (
    .word_i (raw_data_i),
    .kind_o (kind),
    .bytes_o(kind_bytes)
  );

  xtr_frame_fsm #(
    .DATA_W(DATA_W), .BYTES_W(BYTES_W), .HDR_WORDS(HDR_WORDS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .word_i      (raw_data_i),
    .kind_i      (kind),
    .bytes_i     (kind_bytes),
    .beat_o      (beat_nxt),
    .beat_bytes_o(bytes_nxt),
    .beat_data_o (data_nxt),
    .state_o     (state),
    .esc_o       (esc)
  );

  xtr_beat_reg #(
    .DATA_W(DATA_W), .BYTES_W(BYTES_W)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat_nxt),
    .bytes_i(bytes_nxt),
    .data_i (data_nxt),
    .beat_o (beat_q),
    .bytes_o(out_bytes_o),
    .data_o (out_data_o)
  );

  assign out_valid_o = beat_q.valid;
  assign out_abort_o = beat_q.abort;
  assign out_last_o  = beat_q.last;
  assign out_hdr_o   = beat_q.hdr;

  assert_idle_dropped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !esc && kind == K_IDLE && state == ST_PAYLOAD) |=> (!out_valid_o && !out_abort_o))
    else $error("not-ready code produced output");

  assert_abort_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !esc && kind == K_ABORT && state == ST_PAYLOAD) |=> (out_abort_o && state == ST_HEADER))
    else $error("abort did not end the frame");

  assert_final_is_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !esc && kind != K_ESCAPE && state == ST_FINAL) |=> (out_last_o && state == ST_HEADER))
    else $error("armed final word not emitted as last");

  assert_escape_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !esc && kind == K_ESCAPE) |=> (!out_valid_o && !out_abort_o && esc))
    else $error("escape code leaked");

  assert_escaped_literal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && esc) |=> (out_valid_o && !esc))
    else $error("escaped word not emitted");

  assert_last_from_final_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> ($past(state) == ST_FINAL))
    else $error("last beat outside final state");

endmodule

// File: tb/xtr_word_decoder_tb_top.sv
`timescale 1ns/1ps
module xtr_word_decoder_tb_top;
  localparam int          HDR     = 2;
  localparam logic [31:0] C_EOF0  = 32'h8000_0000;
  localparam logic [31:0] C_PRUNE = 32'h8000_0004;
  localparam logic [31:0] C_ESC   = 32'h8000_0005;
  localparam logic [31:0] C_ABORT = 32'h8000_0006;
  localparam logic [31:0] C_IDLE  = 32'h8000_0007;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw_data = '0;
  logic        raw_valid = 1'b0;
  logic        raw_ready;
  logic [31:0] out_data;
  logic [2:0]  out_bytes;
  logic        out_valid, out_last, out_hdr, out_abort;

  always #2.5 clk = ~clk;

  xtr_word_decoder #(.HDR_WORDS(HDR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .raw_data_i(raw_data), .raw_valid_i(raw_valid), .raw_ready_o(raw_ready),
    .out_data_o(out_data), .out_bytes_o(out_bytes), .out_valid_o(out_valid),
    .out_last_o(out_last), .out_hdr_o(out_hdr), .out_abort_o(out_abort)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference state
  int    m_hdr_cnt = 0;
  bit    m_final = 0, m_esc = 0, m_pruned = 0, m_ended = 0;
  int    m_fb = 0;
  bit    ev = 0, ea = 0, el = 0, eh = 0;
  int    eb = 0;
  logic [31:0] ed = '0;
  string etag = "R1";

  function automatic int kind_of(logic [31:0] w);
    if (w >= C_EOF0 && w <= C_EOF0 + 3) return 1;
    if (w == C_PRUNE) return 2;
    if (w == C_ABORT) return 3;
    if (w == C_ESC)   return 4;
    if (w == C_IDLE)  return 5;
    return 0;
  endfunction

  task automatic emit(logic [31:0] w);
    ev = 1; ed = w;
    if (m_final) begin
      el = 1; eb = m_fb; m_final = 0; m_hdr_cnt = 0; m_ended = 1;
      if (m_pruned && etag == "R6") etag = "R7";
    end else if (m_hdr_cnt < HDR) begin
      eh = 1; eb = 4;
      if (m_hdr_cnt == 0 && m_ended) etag = "R12";
      m_hdr_cnt++;
    end else begin
      eb = 4;
    end
  endtask

  task automatic model(bit v, logic [31:0] w);
    int k;
    ev = 0; ea = 0; el = 0; eh = 0; eb = 0; ed = w; etag = "R2";
    if (!v) return;
    k = kind_of(w);
    if (m_esc) begin
      m_esc = 0;
      etag = m_final ? "R9" : "R8";
      emit(w);
    end else if (m_final) begin
      if (k == 4) begin m_esc = 1; etag = "R9"; end
      else begin etag = (k == 0) ? "R6" : "R10"; emit(w); end
    end else if (m_hdr_cnt < HDR) begin
      if (k == 0) begin etag = "R3"; emit(w); end
      else if (k == 4) begin m_esc = 1; etag = "R8"; end
      else if (k == 5 && m_hdr_cnt == 0) etag = "R4";
      else begin ea = 1; m_hdr_cnt = 0; etag = "R11"; end
    end else begin
      case (k)
        0: begin etag = "R2"; emit(w); end
        1: begin m_final = 1; m_pruned = 0; m_fb = (w == C_EOF0) ? 4 : int'(w - C_EOF0); etag = "R6"; end
        2: begin m_final = 1; m_pruned = 1; m_fb = 4; etag = "R7"; end
        3: begin ea = 1; m_hdr_cnt = 0; etag = "R5"; end
        4: begin m_esc = 1; etag = "R8"; end
        default: etag = "R4";
      endcase
    end
  endtask

  task automatic check();
    bit bad;
    n_tests++;
    bad = (out_valid !== ev) || (out_abort !== ea) || (out_last !== el) || (out_hdr !== eh);
    if (ev && ((out_bytes !== 3'(eb)) || (out_data !== ed))) bad = 1;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got v%0b a%0b l%0b h%0b b%0d d%h, expected v%0b a%0b l%0b h%0b b%0d d%h",
               etag, out_valid, out_abort, out_last, out_hdr, out_bytes, out_data,
               ev, ea, el, eh, eb, ed);
    end
  endtask

  task automatic step(bit v, logic [31:0] w);
    @(negedge clk);
    check();
    raw_valid = v;
    raw_data  = w;
    model(v, w);
  endtask

  task automatic hdr_words();
    step(1, 32'h0A00_0001);
    step(1, 32'h0A00_0002);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid || out_abort || out_last || out_hdr || raw_ready) begin
      n_fail++;
      $display("FAIL R1: got v%0b a%0b l%0b h%0b rdy%0b, expected all 0 in reset",
               out_valid, out_abort, out_last, out_hdr, raw_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (!raw_ready || out_valid || out_abort) begin
      n_fail++;
      $display("FAIL R1: got rdy%0b v%0b a%0b, expected rdy1 v0 a0", raw_ready, out_valid, out_abort);
    end

    // frame: idle before header (R4), header (R3), payload with not-ready, EOF k=2 (R6)
    step(1, C_IDLE);
    hdr_words();
    step(1, 32'h1111_0001);
    step(1, C_IDLE);
    step(0, 32'h0);
    step(1, 32'h1111_0002);
    step(1, C_EOF0 + 2);
    step(1, 32'h1111_00EE);
    // next frame (R12): escaped codes in payload (R8), escape after EOF k=3 (R9)
    hdr_words();
    step(1, C_ESC); step(1, C_EOF0);
    step(1, C_ESC); step(1, C_ESC);
    step(1, C_EOF0 + 3);
    step(1, C_ESC); step(1, C_ABORT);
    // abort in payload (R5)
    hdr_words();
    step(1, 32'h2222_0001);
    step(1, C_ABORT);
    // header error on not-ready mid-header (R11), then EOF k=1 with not-ready as final (R10)
    step(1, 32'h0A00_0009);
    step(1, C_IDLE);
    hdr_words();
    step(1, C_EOF0 + 1);
    step(1, C_IDLE);
    // escaped header word, pruned (R7)
    step(1, C_ESC); step(1, C_IDLE);
    step(1, 32'h0A00_0003);
    step(1, C_PRUNE);
    step(1, 32'h3333_0001);
    // header error on EOF at header start (R11), EOF k=0 full final word (R6)
    step(1, C_EOF0);
    hdr_words();
    step(1, C_EOF0);
    step(1, 32'h4444_0001);
    // final word that is a control code other than not-ready (R10)
    hdr_words();
    step(1, C_PRUNE);
    step(1, C_EOF0 + 2);

    // mixed stream
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit v;
      logic [31:0] w;
      r = int'($urandom % 20);
      v = ($urandom % 8) != 0;
      if (r < 11)       w = 32'h1000_0000 | ($urandom & 32'h00FF_FFFF);
      else if (r == 11) w = C_IDLE;
      else if (r == 12 || r == 13) w = C_ESC;
      else if (r == 14) w = C_ABORT;
      else if (r == 15) w = C_PRUNE;
      else              w = C_EOF0 + ($urandom % 4);
      step(v, w);
    end
    step(0, 32'h0);
    step(0, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule